// File: doc/BRIEF.md
# Misaligned Access Split Sequencer

This block takes one load or store request from a processor pipeline and carries it out as one or two transfer tenures on a bus with eight byte lanes. A request gives a byte address, a size (1, 2, 4 or 8 bytes), a direction and, for stores, right-justified big-endian data. For every tenure the block drives the full address, a 3-bit size code and a byte-lane enable mask. It places store bytes on their lanes, and it gathers load bytes from one or two tenures into a single right-justified result.

A request that would cross a 4-byte word boundary is cut at that boundary. The first tenure moves the bytes up to the boundary from the original address. The second moves the rest from the next word address, with the carry propagated into the upper address bits, and it is issued only after the first has been acknowledged. A configuration input selects a 32-bit bus, on which a doubleword is moved as two beats over lanes 0–3. A caching-inhibited instruction fetch is always moved as a word.

The controller has four states. `ST_IDLE` accepts a request (IDLE→TEN1 on `req_valid`). `ST_TEN1` presents the first tenure or beat; on `bus_ack` it goes to `ST_TEN2` if a second phase is needed (TEN1→TEN2) or else to `ST_RESP` (TEN1→RESP). `ST_TEN2` presents the second tenure or beat and moves to `ST_RESP` on `bus_ack` (TEN2→RESP). `ST_RESP` gives the one-cycle response and always returns to `ST_IDLE` (RESP→IDLE).

Top module: `split_bus_seq`

## Requirements
- R1: The size code `bus_tsiz` is 001, 010, 011 or 100 for a tenure of 1, 2, 3 or 4 bytes, and 000 for a doubleword tenure or beat.
- R2: Bit i of `bus_lanes` enables lane i, and lane i carries the byte whose low three address bits equal i. The lowest enabled lane equals `bus_addr[2:0]`, and as many lanes as the size code counts are enabled upward from it.
- R3: A 4-byte request with low address bits 000 or 100 takes one tenure with size code 100 and lanes 0–3 or lanes 4–7.
- R4: A 4-byte request at word offset k (1, 2 or 3) takes two tenures. The first moves 4−k bytes at the request address. The second moves k bytes at the next 4-byte-aligned address. No tenure crosses a word boundary.
- R5: When the request starts at low bits 101, 110 or 111, the second tenure has low bits 000, starts on lane 0, and its upper address bits are the request's upper bits plus one doubleword, carry included.
- R6: 1- and 2-byte requests that fit inside a word take one tenure with the matching size code. A 2-byte request at word offset 3 is split into two 1-byte tenures.
- R7: An 8-byte request ignores the low three address bits. With `cfg_bus32`=0 it takes one tenure with size code 000 and all eight lanes. With `cfg_bus32`=1 it takes two beats at the same address, each with size code 000 and lanes 0–3; the first beat carries request bytes 0–3 and the second carries bytes 4–7.
- R8: With `req_ifetch_ci`=1, the request is a 4-byte read whatever `req_size` and `req_write` hold.
- R9: Store byte j of an N-byte request (byte 0 is the most significant byte of the low N bytes of `req_wdata`) is driven on the lane of address request+j in the tenure that covers it. Byte j of lane i sits at `bus_wdata[8*(7-i)+:8]`.
- R10: `rsp_valid` is high for exactly one cycle, the cycle after the last acknowledge. For a load, `rsp_rdata` then holds the bytes from all tenures as a right-justified big-endian value; for a store it is zero.
- R11: The second tenure or beat is presented only after the first is acknowledged, and all tenure outputs stay unchanged until `bus_ack`.
- R12: `req_ready` is high only in the idle state. It is low from the cycle after acceptance until the response cycle has ended.

Size field `req_size`: 00 = 1 byte, 01 = 2 bytes, 10 = 4 bytes, 11 = 8 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_bus32 | input | 1 | 1 selects 32-bit bus mode (doubleword in two beats) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_addr | input | 32 | Request byte address |
| req_size | input | 2 | Request size code (1/2/4/8 bytes) |
| req_write | input | 1 | 1 for store, 0 for load |
| req_ifetch_ci | input | 1 | Caching-inhibited instruction fetch, forces 4-byte read |
| req_wdata | input | 64 | Store data, right-justified big-endian |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 64 | Load result, right-justified big-endian |
| bus_req | output | 1 | Tenure or beat presented |
| bus_write | output | 1 | Tenure direction |
| bus_addr | output | 32 | Tenure address |
| bus_tsiz | output | 3 | Tenure size code |
| bus_lanes | output | 8 | Byte-lane enables, bit i is lane i |
| bus_wdata | output | 64 | Store data on lanes, lane 0 in the top byte |
| bus_ack | input | 1 | Completes the presented tenure or beat |
| bus_rdata | input | 64 | Load data on lanes, valid with bus_ack |

## Verification
The collision of interest is the final acknowledge of a split load, with its byte merge and response, falling in the cycle where the next request is already waiting at the input. The bench holds `req_valid` high across back-to-back split requests while the bus responder acknowledges with no wait cycles. The scoreboard then judges that the response carries only the old request's merged bytes, and that the waiting request's first tenure appears only after the response cycle, with `req_ready` low on every tenure.

// File: rtl/split_bus_pkg.sv
package split_bus_pkg;

    // request size field encoding
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } req_size_e;

    // controller states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TEN1 = 2'd1,
        ST_TEN2 = 2'd2,
        ST_RESP = 2'd3
    } seq_state_e;

endpackage

// File: rtl/split_plan.sv
// Decides how a request is cut into phases: addresses, byte counts,
// whether a second phase exists and whether it is a doubleword.
module split_plan
    import split_bus_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LANES  = 8,
    parameter int WORD_B = 4,
    localparam int OFF_W  = $clog2(LANES),
    localparam int CNT_W  = OFF_W + 1,
    localparam int WOFF_W = $clog2(WORD_B)
) (
    input  logic [ADDR_W-1:0] addr,
    input  req_size_e         size,
    input  logic              ci_fetch,
    input  logic              bus32,
    output logic [ADDR_W-1:0] addr_a,
    output logic [ADDR_W-1:0] addr_b,
    output logic [CNT_W-1:0]  cnt_a,
    output logic [CNT_W-1:0]  cnt_b,
    output logic [CNT_W-1:0]  total,
    output logic              two_phase,
    output logic              is_dword
);

    logic [WOFF_W-1:0] word_off;
    logic [CNT_W-1:0]  room;
    logic [ADDR_W-1:0] word_base;

    always_comb begin
        total     = ci_fetch ? CNT_W'(WORD_B) : (CNT_W'(1) << size);
        is_dword  = (total == CNT_W'(LANES));
        word_off  = addr[WOFF_W-1:0];
        room      = CNT_W'(WORD_B) - CNT_W'(word_off);
        word_base = {addr[ADDR_W-1:WOFF_W], WOFF_W'(0)};

        if (is_dword) begin
            addr_a    = {addr[ADDR_W-1:OFF_W], OFF_W'(0)};
            addr_b    = addr_a;
            cnt_a     = bus32 ? CNT_W'(WORD_B) : CNT_W'(LANES);
            cnt_b     = CNT_W'(WORD_B);
            two_phase = bus32;
        end else if (total <= room) begin
            addr_a    = addr;
            addr_b    = addr;
            cnt_a     = total;
            cnt_b     = '0;
            two_phase = 1'b0;
        end else begin
            addr_a    = addr;
            addr_b    = word_base + ADDR_W'(WORD_B);
            cnt_a     = room;
            cnt_b     = total - room;
            two_phase = 1'b1;
        end
    end

endmodule

// File: rtl/split_lanes.sv
// Lane steering for one phase: enable mask, store data placed on lanes,
// and the load bytes of this phase moved into a left-justified accumulator.
module split_lanes #(
    parameter int LANES = 8,
    localparam int OFF_W = $clog2(LANES),
    localparam int CNT_W = OFF_W + 1,
    localparam int DW    = 8 * LANES
) (
    input  logic [OFF_W-1:0] lane,
    input  logic [CNT_W-1:0] skip,
    input  logic [CNT_W-1:0] cnt,
    input  logic [DW-1:0]    lj_wdata,
    input  logic [DW-1:0]    rdata,
    output logic [LANES-1:0] mask,
    output logic [DW-1:0]    wlanes,
    output logic [DW-1:0]    rpiece
);

    logic [LANES-1:0] low_ones;
    logic [DW-1:0]    byte_mask;
    logic [DW-1:0]    top_mask;

    assign low_ones = (LANES'(1) << cnt) - LANES'(1);
    assign mask     = low_ones << lane;

    for (genvar gi = 0; gi < LANES; gi++) begin : g_bytes
        assign byte_mask[8*(LANES-1-gi) +: 8] = {8{mask[gi]}};
    end

    assign top_mask = ~DW'(0) << {CNT_W'(LANES) - cnt, 3'b000};
    assign wlanes   = ((lj_wdata << {skip, 3'b000}) >> {lane, 3'b000}) & byte_mask;
    assign rpiece   = ((rdata << {lane, 3'b000}) & top_mask) >> {skip, 3'b000};

endmodule

// File: rtl/split_bus_seq.sv
module split_bus_seq
    import split_bus_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LANES  = 8,
    parameter int WORD_B = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_bus32,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [1:0]               req_size,
    input  logic                     req_write,
    input  logic                     req_ifetch_ci,
    input  logic [8*LANES-1:0]       req_wdata,
    output logic                     rsp_valid,
    output logic [8*LANES-1:0]       rsp_rdata,
    output logic                     bus_req,
    output logic                     bus_write,
    output logic [ADDR_W-1:0]        bus_addr,
    output logic [$clog2(LANES)-1:0] bus_tsiz,
    output logic [LANES-1:0]         bus_lanes,
    output logic [8*LANES-1:0]       bus_wdata,
    input  logic                     bus_ack,
    input  logic [8*LANES-1:0]       bus_rdata
);

    localparam int DW    = 8 * LANES;
    localparam int OFF_W = $clog2(LANES);
    localparam int CNT_W = OFF_W + 1;

    seq_state_e state, state_nx;

    // decoded plan of the incoming request
    logic [ADDR_W-1:0] p_addr_a, p_addr_b;
    logic [CNT_W-1:0]  p_cnt_a, p_cnt_b, p_total;
    logic              p_two, p_dword;

    // registered plan of the request in flight
    logic [ADDR_W-1:0] r_addr_a, r_addr_b;
    logic [CNT_W-1:0]  r_cnt_a, r_cnt_b, r_total;
    logic              r_two, r_dword, r_wr;
    logic [DW-1:0]     r_lj, r_acc;

    logic              accept;

    split_plan #(
        .ADDR_W(ADDR_W), .LANES(LANES), .WORD_B(WORD_B)
    ) u_plan (
        .addr      (req_addr),
        .size      (req_size_e'(req_size)),
        .ci_fetch  (req_ifetch_ci),
        .bus32     (cfg_bus32),
        .addr_a    (p_addr_a),
        .addr_b    (p_addr_b),
        .cnt_a     (p_cnt_a),
        .cnt_b     (p_cnt_b),
        .total     (p_total),
        .two_phase (p_two),
        .is_dword  (p_dword)
    );

    // per-phase lane steering
    logic [ADDR_W-1:0] ph_addr [2];
    logic [CNT_W-1:0]  ph_cnt  [2];
    logic [CNT_W-1:0]  ph_skip [2];
    logic [LANES-1:0]  ph_mask [2];
    logic [DW-1:0]     ph_w    [2];
    logic [DW-1:0]     ph_r    [2];

    assign ph_addr[0] = r_addr_a;
    assign ph_addr[1] = r_addr_b;
    assign ph_cnt[0]  = r_cnt_a;
    assign ph_cnt[1]  = r_cnt_b;
    assign ph_skip[0] = '0;
    assign ph_skip[1] = r_cnt_a;

    for (genvar gp = 0; gp < 2; gp++) begin : g_phase
        split_lanes #(.LANES(LANES)) u_lanes (
            .lane     (ph_addr[gp][OFF_W-1:0]),
            .skip     (ph_skip[gp]),
            .cnt      (ph_cnt[gp]),
            .lj_wdata (r_lj),
            .rdata    (bus_rdata),
            .mask     (ph_mask[gp]),
            .wlanes   (ph_w[gp]),
            .rpiece   (ph_r[gp])
        );
    end

    assign accept = (state == ST_IDLE) && req_valid;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nx = ST_TEN1;
            ST_TEN1: if (bus_ack)   state_nx = r_two ? ST_TEN2 : ST_RESP;
            ST_TEN2: if (bus_ack)   state_nx = ST_RESP;
            ST_RESP: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // request plan and read accumulator
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_addr_a <= '0;
            r_addr_b <= '0;
            r_cnt_a  <= '0;
            r_cnt_b  <= '0;
            r_total  <= '0;
            r_two    <= 1'b0;
            r_dword  <= 1'b0;
            r_wr     <= 1'b0;
            r_lj     <= '0;
            r_acc    <= '0;
        end else if (accept) begin
            r_addr_a <= p_addr_a;
            r_addr_b <= p_addr_b;
            r_cnt_a  <= p_cnt_a;
            r_cnt_b  <= p_cnt_b;
            r_total  <= p_total;
            r_two    <= p_two;
            r_dword  <= p_dword;
            r_wr     <= req_write & ~req_ifetch_ci;
            r_lj     <= req_wdata << {CNT_W'(LANES) - p_total, 3'b000};
            r_acc    <= '0;
        end else if (bus_ack && state == ST_TEN1) begin
            r_acc    <= r_acc | ph_r[0];
        end else if (bus_ack && state == ST_TEN2) begin
            r_acc    <= r_acc | ph_r[1];
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_rdata = '0;
        bus_req   = 1'b0;
        bus_write = 1'b0;
        bus_addr  = '0;
        bus_tsiz  = '0;
        bus_lanes = '0;
        bus_wdata = '0;
        unique case (state)
            ST_IDLE: req_ready = 1'b1;
            ST_TEN1: begin
                bus_req   = 1'b1;
                bus_write = r_wr;
                bus_addr  = r_addr_a;
                bus_tsiz  = r_dword ? '0 : r_cnt_a[OFF_W-1:0];
                bus_lanes = ph_mask[0];
                bus_wdata = r_wr ? ph_w[0] : '0;
            end
            ST_TEN2: begin
                bus_req   = 1'b1;
                bus_write = r_wr;
                bus_addr  = r_addr_b;
                bus_tsiz  = r_dword ? '0 : r_cnt_b[OFF_W-1:0];
                bus_lanes = ph_mask[1];
                bus_wdata = r_wr ? ph_w[1] : '0;
            end
            ST_RESP: begin
                rsp_valid = 1'b1;
                rsp_rdata = r_wr ? '0 : (r_acc >> {CNT_W'(LANES) - r_total, 3'b000});
            end
        endcase
    end

endmodule

// File: rtl/split_bus_chk.sv
module split_bus_chk #(
    parameter int LANES  = 8,
    parameter int WORD_B = 4,
    localparam int OFF_W = $clog2(LANES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             bus_req,
    input logic             bus_ack,
    input logic [OFF_W-1:0] addr_lo,
    input logic [OFF_W-1:0] bus_tsiz,
    input logic [LANES-1:0] bus_lanes
);

    // R12
    busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !req_ready);

    // R12
    accept_starts_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> bus_req && !req_ready);

    // R11
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(addr_lo) && $stable(bus_tsiz) && $stable(bus_lanes));

    // R2
    lane_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_tsiz != '0 |->
            bus_lanes == (LANES'((LANES'(1) << bus_tsiz) - LANES'(1)) << addr_lo));

    // R4
    no_word_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_tsiz != '0 |-> (int'(addr_lo) % WORD_B) + int'(bus_tsiz) <= WORD_B);

    // R7
    dword_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_tsiz == '0 |->
            addr_lo == '0 && ($countones(bus_lanes) == LANES || $countones(bus_lanes) == WORD_B));

    // R10
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid && req_ready);

endmodule

bind split_bus_seq split_bus_chk #(
    .LANES(LANES), .WORD_B(WORD_B)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .bus_req   (bus_req),
    .bus_ack   (bus_ack),
    .addr_lo   (bus_addr[$clog2(LANES)-1:0]),
    .bus_tsiz  (bus_tsiz),
    .bus_lanes (bus_lanes)
);

// File: tb/sim_split_bus_seq.sv
module sim_split_bus_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_bus32 = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic        req_ifetch_ci = 1'b0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        bus_req, bus_write;
    logic [31:0] bus_addr;
    logic [2:0]  bus_tsiz;
    logic [7:0]  bus_lanes;
    logic [63:0] bus_wdata;
    logic        bus_ack = 1'b0;
    logic [63:0] bus_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    int ack_delay = -1;
    int rot = 0;
    bit finished = 0;

    always #10 clk = ~clk;  // 50 MHz

    split_bus_seq u0 (
        .clk(clk), .rst_n(rst_n), .cfg_bus32(cfg_bus32),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_ifetch_ci(req_ifetch_ci),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .bus_req(bus_req), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_tsiz(bus_tsiz), .bus_lanes(bus_lanes), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    typedef struct {
        logic [31:0] addr;
        logic [2:0]  tsiz;
        logic [7:0]  lanes;
        logic        wr;
        logic [31:0] rbase;   // address carried by lane 0
        logic [31:0] rstart;  // address of request byte 0
        int          rn;
        logic [63:0] wd;
        int          tag;
    } ten_t;

    typedef struct {
        logic [63:0] data;
        int          tag;
    } rsp_t;

    ten_t tq[$];
    rsp_t rq[$];

    function automatic logic [7:0] mem_byte(logic [31:0] a);
        return (a[7:0] * 8'd29) ^ a[15:8] ^ a[23:16] ^ 8'h3C;
    endfunction

    function automatic logic [7:0] lmask(int off, int n);
        return 8'(((1 << n) - 1) << off);
    endfunction

    task automatic check(int tag, bit ok, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R%0d: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic push_ten(logic [31:0] a, int n, logic wr, logic [31:0] rstart,
                            int rn, logic [63:0] wd, int tag, logic [31:0] rbase, logic dw);
        ten_t t;
        t.addr = a;
        t.tsiz = dw ? 3'b000 : 3'(n);
        t.lanes = dw ? lmask(0, n) : lmask(int'(a[2:0]), n);
        t.wr = wr;
        t.rbase = rbase;
        t.rstart = rstart;
        t.rn = rn;
        t.wd = wd;
        t.tag = tag;
        tq.push_back(t);
    endtask

    // driver: builds the expected tenures and response, then presents the request
    task automatic send(logic [31:0] a, logic [1:0] sz, logic wr, logic [63:0] wd,
                        logic ci, int tag);
        int n;
        logic w;
        logic [31:0] start;
        rsp_t r;
        n = ci ? 4 : (1 << sz);
        w = wr && !ci;
        if (n == 8) begin
            start = {a[31:3], 3'b000};
            if (cfg_bus32) begin
                push_ten(start, 4, w, start, 8, wd, tag, start, 1'b1);
                push_ten(start, 4, w, start, 8, wd, tag, start + 4, 1'b1);
            end else begin
                push_ten(start, 8, w, start, 8, wd, tag, start, 1'b1);
            end
        end else begin
            int k, room;
            logic [31:0] a2;
            start = a;
            k = int'(a[1:0]);
            room = 4 - k;
            if (n <= room) begin
                push_ten(a, n, w, start, n, wd, tag, {a[31:3], 3'b000}, 1'b0);
            end else begin
                a2 = {a[31:2], 2'b00} + 32'd4;
                push_ten(a, room, w, start, n, wd, tag, {a[31:3], 3'b000}, 1'b0);
                push_ten(a2, n - room, w, start, n, wd, tag, {a2[31:3], 3'b000}, 1'b0);
            end
        end
        r.data = '0;
        if (!w) for (int j = 0; j < n; j++) r.data = (r.data << 8) | 64'(mem_byte(start + 32'(j)));
        r.tag = tag;
        rq.push_back(r);
        req_valid = 1'b1;
        req_addr = a;
        req_size = sz;
        req_write = wr;
        req_ifetch_ci = ci;
        req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic settle();
        req_valid = 1'b0;
        while (!(req_ready && tq.size() == 0 && rq.size() == 0 && !finished)) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // bus responder and tenure monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && bus_req) begin
                int dly;
                if (tq.size() == 0) begin
                    check(11, 1'b0, {32'd0, bus_addr}, 64'hFFFF_FFFF);
                end else begin
                    ten_t t;
                    logic [63:0] exp_w, bm, rd;
                    t = tq.pop_front();
                    check(t.tag, {bus_addr, bus_tsiz, bus_lanes, bus_write} ==
                                 {t.addr, t.tsiz, t.lanes, t.wr},
                          {20'd0, bus_addr, bus_tsiz, bus_lanes, bus_write},
                          {20'd0, t.addr, t.tsiz, t.lanes, t.wr});
                    // R12: no request taken during a tenure
                    check(12, req_ready == 1'b0, 64'(req_ready), 64'd0);
                    exp_w = '0;
                    bm = '0;
                    rd = '0;
                    for (int i = 0; i < 8; i++) begin
                        rd[8*(7-i) +: 8] = mem_byte(t.rbase + 32'(i));
                        if (t.lanes[i]) begin
                            int j;
                            j = int'(t.rbase + 32'(i) - t.rstart);
                            bm[8*(7-i) +: 8] = 8'hFF;
                            exp_w[8*(7-i) +: 8] = t.wd[8*(t.rn-1-j) +: 8];
                        end
                    end
                    if (t.wr) begin
                        // R9: store bytes on their lanes
                        check(9, (bus_wdata & bm) == exp_w, bus_wdata & bm, exp_w);
                    end
                    bus_rdata = rd;
                end
                if (ack_delay >= 0) dly = ack_delay;
                else begin
                    dly = rot % 3;
                    rot++;
                end
                repeat (dly) @(negedge clk);
                bus_ack = 1'b1;
                @(negedge clk);
                bus_ack = 1'b0;
            end
        end
    end

    // response monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rsp_valid) begin
                if (rq.size() == 0) begin
                    check(10, 1'b0, rsp_rdata, 64'd0);
                end else begin
                    rsp_t r;
                    r = rq.pop_front();
                    // R10: merged, right-justified result
                    check(10, rsp_rdata == r.data, rsp_rdata, r.data);
                end
            end
        end
    end

    task automatic finish_run();
        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R11: watchdog expired, actual busy expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check(12, req_ready == 1'b1 && bus_req == 1'b0 && rsp_valid == 1'b0,
              {61'd0, req_ready, bus_req, rsp_valid}, 64'h4);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3: aligned words, lower and upper half
        send(32'h0000_1000, 2'b10, 1'b0, 64'd0, 1'b0, 3); settle();
        send(32'h0000_1004, 2'b10, 1'b1, 64'h0000_0000_A1B2_C3D4, 1'b0, 3); settle();

        // R4: split at offsets 1, 2, 3 in the lower word (R1 size codes 011/010/001)
        send(32'h0000_2001, 2'b10, 1'b0, 64'd0, 1'b0, 4); settle();
        send(32'h0000_2002, 2'b10, 1'b1, 64'h0000_0000_1122_3344, 1'b0, 4); settle();
        send(32'h0000_2003, 2'b10, 1'b0, 64'd0, 1'b0, 1); settle();

        // R5: offsets 5, 6, 7, second tenure on lane 0 of next doubleword
        send(32'h0000_3005, 2'b10, 1'b1, 64'h0000_0000_5566_7788, 1'b0, 5); settle();
        send(32'h0000_3006, 2'b10, 1'b0, 64'd0, 1'b0, 5); settle();
        send(32'h0000_3007, 2'b10, 1'b0, 64'd0, 1'b0, 5); settle();
        // R5: carry into the upper address bits
        send(32'h0000_FFFF, 2'b10, 1'b0, 64'd0, 1'b0, 5); settle();
        send(32'h00FF_FFFE, 2'b10, 1'b1, 64'h0000_0000_DEAD_BEEF, 1'b0, 5); settle();

        // R6: bytes and halves inside a word, halves crossing a word
        send(32'h0000_4006, 2'b00, 1'b1, 64'h0000_0000_0000_00E7, 1'b0, 6); settle();
        send(32'h0000_4005, 2'b00, 1'b0, 64'd0, 1'b0, 6); settle();
        send(32'h0000_4002, 2'b01, 1'b0, 64'd0, 1'b0, 6); settle();
        send(32'h0000_4003, 2'b01, 1'b1, 64'h0000_0000_0000_9A8B, 1'b0, 6); settle();
        send(32'h0000_4007, 2'b01, 1'b0, 64'd0, 1'b0, 6); settle();

        // R7: doubleword on the full bus, low address bits ignored
        send(32'h0000_5000, 2'b11, 1'b0, 64'd0, 1'b0, 7); settle();
        send(32'h0000_5805, 2'b11, 1'b1, 64'h0102_0304_0506_0708, 1'b0, 7); settle();

        // R8: caching-inhibited fetch forced to a 4-byte read
        send(32'h0000_6004, 2'b00, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 8); settle();
        send(32'h0000_6008, 2'b11, 1'b0, 64'd0, 1'b1, 8); settle();

        // R7: 32-bit bus mode, doubleword as two beats
        cfg_bus32 = 1'b1;
        send(32'h0000_7000, 2'b11, 1'b0, 64'd0, 1'b0, 7); settle();
        send(32'h0000_7808, 2'b11, 1'b1, 64'h8877_6655_4433_2211, 1'b0, 7); settle();
        send(32'h0000_7003, 2'b10, 1'b0, 64'd0, 1'b0, 4); settle();
        cfg_bus32 = 1'b0;

        // R10 and R12: back-to-back split loads, zero-wait acknowledge,
        // next request held while the merge and response happen
        ack_delay = 0;
        send(32'h0000_8001, 2'b10, 1'b0, 64'd0, 1'b0, 10);
        send(32'h0000_8107, 2'b10, 1'b0, 64'd0, 1'b0, 10);
        send(32'h0000_8203, 2'b01, 1'b0, 64'd0, 1'b0, 10);
        send(32'h0000_8306, 2'b10, 1'b1, 64'h0000_0000_CAFE_F00D, 1'b0, 9);
        settle();
        ack_delay = 2;
        send(32'h0000_9FFD, 2'b10, 1'b0, 64'd0, 1'b0, 11);
        send(32'h0000_A000, 2'b11, 1'b0, 64'd0, 1'b0, 11);
        settle();
        ack_delay = -1;

        // R11: nothing left pending
        check(11, tq.size() == 0 && rq.size() == 0,
              64'(tq.size() + rq.size()), 64'd0);
        finish_run();
    end

endmodule